// File: doc/BRIEF.md
# Glitch-Free Output Clock Stop Controller

This block sits between a bank of already-generated clocks and the pins that carry them. It turns each clock off and on without ever producing a shortened pulse. An output that is off is held low. Each output has its own enable bit, driven from a configuration register outside this block. The outputs also form four groups: processor, memory, peripheral bus and free-running.

Two active-low stop inputs act on groups of outputs. The host stop input gates the processor and memory groups. The bus stop input gates the peripheral bus group. The free-running group ignores both. A strap input can switch the stop inputs off, and then they are treated as deasserted. After reset, every output stays low until a settle counter has counted a parameterised number of reference-clock cycles. This gives the upstream oscillator time to stabilise.

Every change is taken in two steps. First, a rising edge of the free-running reference clock arms the new state. Then the next falling edge of the affected output's own source clock commits it. The gate can therefore only change while that source is low.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_gated_o` is low.
- R2: After reset is released, every output stays low until SETTLE_CYCLES rising edges of `ref_clk` have occurred. The internal ready flag, once set, never clears until the next reset.
- R3: A stopped or disabled output is held at logic low, never high.
- R4: Every high pulse on an output has the full width of the corresponding high phase of its source clock. Stopping never truncates a pulse, and starting never emits a partial one.
- R5: The stop inputs pass through a two-flop synchronizer clocked by `ref_clk`. A change then needs one more `ref_clk` rising edge to be armed. It reaches the pin only at the next falling edge of that output's source clock.
- R6: With `stop_pins_off_i` = 0, a low on `host_stop_n_i` stops outputs 0 to N_HOST+N_MEM-1, which are the processor and memory groups.
- R7: With `stop_pins_off_i` = 0, a low on `bus_stop_n_i` stops the next N_BUS outputs, which are the peripheral bus group.
- R8: The free-running group, which is the top N_FREE outputs, keeps running whatever either stop input says. Each stop input has no effect on groups it does not own.
- R9: With `stop_pins_off_i` = 1, both stop inputs are ignored and behave as if they were high.
- R10: Output i runs only when `clk_en_i[i]` = 1 and its group's stop input allows it. Enable bit value 1 means run.
- R11: Each output arms and commits on its own. Disabling one output does not change any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that qualifies every change |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pins_off_i | input | 1 | Strap: 1 ignores both stop inputs |
| host_stop_n_i | input | 1 | Active-low stop for the processor and memory groups (asynchronous) |
| bus_stop_n_i | input | 1 | Active-low stop for the peripheral bus group (asynchronous) |
| clk_en_i | input | N_OUT | Per-output enable bits (1 = run) |
| clk_src_i | input | N_OUT | Ungated source clocks |
| clk_gated_o | output | N_OUT | Gated output clocks |

## Verification
The bench drives source clocks with three different periods, so that commit points fall at different phases for different outputs. It compares every output against a behavioural model on every reference cycle. That model tracks arm and commit delays exactly. A design that sampled the stop inputs too early or too late, or that committed on the wrong edge, would therefore differ in a single cycle. Every completed high pulse is measured. A gate that changed while a source was high would produce a short pulse and be reported. Scenario windows stop each group in turn, override the stops with the strap, and mask single outputs. A wrong group map, an inverted strap, or an enable that leaked into a neighbour would show as a window where the wrong outputs toggle.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

   typedef enum logic [1:0] {
      GRP_HOST = 2'd0,
      GRP_MEM  = 2'd1,
      GRP_BUS  = 2'd2,
      GRP_FREE = 2'd3
   } clk_grp_e;

   // Outputs are laid out low to high: host, memory, bus, free-running.
   function automatic clk_grp_e grp_of(input int idx, input int nh,
                                       input int nm, input int nb);
      if (idx < nh)                return GRP_HOST;
      else if (idx < nh + nm)      return GRP_MEM;
      else if (idx < nh + nm + nb) return GRP_BUS;
      else                         return GRP_FREE;
   endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
   parameter int          WIDTH   = 2,
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clkstop_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("clkstop_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= {WIDTH{RST_VAL}};
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];

   // R5: the synchronized value is the first-stage value one edge later
   a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> sync_o == $past(chain_q[STAGES-2]))
      else $error("sync delay broken");
endmodule

// File: rtl/clkstop_settle.sv
`timescale 1ns/1ps
module clkstop_settle #(
   parameter int CYCLES = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready_o
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("clkstop_settle: CYCLES must be at least 1");
   end

   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (!ready_q) begin
         if (cnt_q == LAST) ready_q <= 1'b1;
         else               cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign ready_o = ready_q;

   a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> ready_q)
      else $error("settle flag dropped");
endmodule

// File: rtl/clkstop_gate_cell.sv
`timescale 1ns/1ps
module clkstop_gate_cell (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic src_clk_i,
   input  logic en_i,
   input  logic allow_i,
   input  logic ready_i,
   output logic arm_o,
   output logic clk_o
);
   logic arm_q;
   logic gate_q;

   // Step one: reference rising edge arms the wanted state.
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= en_i & allow_i & ready_i;
   end

   // Step two: the source's own falling edge commits it while the source is low.
   always_ff @(negedge src_clk_i or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= arm_q;
   end

   assign arm_o = arm_q;
   assign clk_o = src_clk_i & gate_q;

   // R10: a cleared enable bit always disarms on the next reference edge
   a_r10_enable_gates: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !en_i |=> !arm_q)
      else $error("armed with enable low");

   // R4: gate holds through a source high phase (sources slower than half ref)
   a_r4_hold_while_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (src_clk_i && $past(src_clk_i)) |-> $stable(gate_q))
      else $error("gate moved while source high");
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
   import clkstop_pkg::*;
#(
   parameter int N_HOST        = 3,
   parameter int N_MEM         = 12,
   parameter int N_BUS         = 6,
   parameter int N_FREE        = 4,
   parameter int SYNC_STAGES   = 2,
   parameter int SETTLE_CYCLES = 100000,
   parameter int N_OUT         = N_HOST + N_MEM + N_BUS + N_FREE
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             stop_pins_off_i,
   input  logic             host_stop_n_i,
   input  logic             bus_stop_n_i,
   input  logic [N_OUT-1:0] clk_en_i,
   input  logic [N_OUT-1:0] clk_src_i,
   output logic [N_OUT-1:0] clk_gated_o
);
   localparam int N_SUM = N_HOST + N_MEM + N_BUS + N_FREE;

   if (N_OUT != N_SUM) begin : g_bad_nout
      $error("clkstop_ctrl: N_OUT must equal the sum of the group sizes");
   end
   if (N_OUT < 1) begin : g_bad_empty
      $error("clkstop_ctrl: at least one output required");
   end

   logic [1:0]       stop_sync;
   logic             host_ok;
   logic             bus_ok;
   logic             ready;
   logic [N_OUT-1:0] allow;
   logic [N_OUT-1:0] arm;

   clkstop_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .async_i ({host_stop_n_i, bus_stop_n_i}),
      .sync_o  (stop_sync)
   );

   clkstop_settle #(
      .CYCLES  (SETTLE_CYCLES)
   ) u_settle (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .ready_o (ready)
   );

   assign host_ok = stop_pins_off_i | stop_sync[1];
   assign bus_ok  = stop_pins_off_i | stop_sync[0];

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      localparam clk_grp_e GRP = grp_of(i, N_HOST, N_MEM, N_BUS);

      if (GRP == GRP_HOST || GRP == GRP_MEM) begin : g_host
         assign allow[i] = host_ok;
         // R6: host stop disarms processor and memory outputs
         a_r6_host_stop: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (!stop_pins_off_i && !stop_sync[1]) |=> !arm[i])
            else $error("host group armed under stop");
      end else if (GRP == GRP_BUS) begin : g_bus
         assign allow[i] = bus_ok;
         // R7: bus stop disarms peripheral outputs
         a_r7_bus_stop: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (!stop_pins_off_i && !stop_sync[0]) |=> !arm[i])
            else $error("bus group armed under stop");
      end else begin : g_free
         assign allow[i] = 1'b1;
         // R8: free outputs arm whenever enabled and settled
         a_r8_free_runs: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (ready && clk_en_i[i]) |=> arm[i])
            else $error("free output not armed");
      end

      clkstop_gate_cell u_cell (
         .ref_clk   (ref_clk),
         .rst_n     (rst_n),
         .src_clk_i (clk_src_i[i]),
         .en_i      (clk_en_i[i]),
         .allow_i   (allow[i]),
         .ready_i   (ready),
         .arm_o     (arm[i]),
         .clk_o     (clk_gated_o[i])
      );

      // R9: with the strap set, stop inputs never keep an enabled output off
      a_r9_strap_override: assert property (@(posedge ref_clk) disable iff (!rst_n)
         (stop_pins_off_i && ready && clk_en_i[i]) |=> arm[i])
         else $error("stop honoured with strap set");
   end

   // R2: nothing reaches the pins before the settle count completes
   a_r2_quiet_until_ready: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !ready |-> (clk_gated_o == '0))
      else $error("output active before settle");
endmodule

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
   localparam int NH = 3, NM = 12, NB = 6, NF = 4;
   localparam int N  = NH + NM + NB + NF;
   localparam int SET = 40;
   localparam logic [N-1:0] M_HM = {{(N-NH-NM){1'b0}}, {(NH+NM){1'b1}}};
   localparam logic [N-1:0] M_B  = {{NF{1'b0}}, {NB{1'b1}}, {(NH+NM){1'b0}}};
   localparam logic [N-1:0] M_F  = {{NF{1'b1}}, {(N-NF){1'b0}}};

   logic ref_clk = 1'b0;
   logic rst_n = 1'b0;
   logic pins_off = 1'b0;
   logic host_n = 1'b1;
   logic bus_n = 1'b1;
   logic [N-1:0] en = '1;
   logic [N-1:0] src = '0;
   logic [N-1:0] gout;

   int nchk = 0;
   int nerr = 0;
   bit finished = 0;

   logic [N-1:0] m_arm = '0;
   logic [N-1:0] m_gate = '0;
   int edges = 0;
   logic [1:0] hist[$];
   int dcnt[N];
   int hcnt[N];

   always #2.5 ref_clk = ~ref_clk;

   clkstop_ctrl #(
      .N_HOST(NH), .N_MEM(NM), .N_BUS(NB), .N_FREE(NF),
      .SYNC_STAGES(2), .SETTLE_CYCLES(SET)
   ) dut_i (
      .ref_clk        (ref_clk),
      .rst_n          (rst_n),
      .stop_pins_off_i(pins_off),
      .host_stop_n_i  (host_n),
      .bus_stop_n_i   (bus_n),
      .clk_en_i       (en),
      .clk_src_i      (src),
      .clk_gated_o    (gout)
   );

   function automatic int div_of(int i);
      return (i % 3) + 1;
   endfunction

   // Source clocks: output i toggles every div_of(i) reference falling edges.
   // Model commit: a source falling edge takes the armed state.
   always @(negedge ref_clk) begin
      for (int i = 0; i < N; i++) begin
         dcnt[i]++;
         if (dcnt[i] >= div_of(i)) begin
            dcnt[i] = 0;
            if (src[i]) m_gate[i] = rst_n ? m_arm[i] : 1'b0;
            src[i] = ~src[i];
         end
      end
   end

   // Model arm: stop inputs seen two edges late, settle after SET edges.
   always @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_arm = '0;
         edges = 0;
         hist.delete();
      end else begin
         logic [1:0] d;
         logic ok;
         d = (hist.size() >= 2) ? hist[0] : 2'b00;
         for (int i = 0; i < N; i++) begin
            if (i < NH + NM)           ok = pins_off | d[1];
            else if (i < NH + NM + NB) ok = pins_off | d[0];
            else                       ok = 1'b1;
            m_arm[i] = en[i] & ok & (edges >= SET);
         end
         hist.push_back({host_n, bus_n});
         if (hist.size() > 2) void'(hist.pop_front());
         edges++;
      end
   end

   // Per-cycle comparison and pulse-width measurement
   always @(negedge ref_clk) begin
      #1;
      nchk++;
      if (gout !== (src & m_gate)) begin
         nerr++;
         $display("FAIL R5 model mismatch t=%0t act=%h exp=%h", $time, gout, src & m_gate);
      end
      for (int i = 0; i < N; i++) begin
         if (gout[i] === 1'b1) hcnt[i]++;
         else if (hcnt[i] > 0) begin
            nchk++;
            if (hcnt[i] != div_of(i)) begin
               nerr++;
               $display("FAIL R4 pulse width out %0d act=%0d exp=%0d", i, hcnt[i], div_of(i));
            end
            hcnt[i] = 0;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                        input logic [N-1:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic observe(input int n, output logic [N-1:0] hi);
      hi = '0;
      repeat (n) begin
         @(negedge ref_clk); #1;
         hi |= gout;
      end
   endtask

   task automatic settle_wait();
      repeat (10) @(negedge ref_clk);
   endtask

   initial begin
      logic [N-1:0] hi;
      for (int i = 0; i < N; i++) begin dcnt[i] = 0; hcnt[i] = 0; end
      repeat (6) @(negedge ref_clk);
      #1;
      check(gout == '0, "R1 reset low", gout, '0);
      @(negedge ref_clk);
      rst_n = 1'b1;

      observe(SET - 8, hi);
      check(hi == '0, "R2 quiet before settle", hi, '0);
      repeat (10) @(negedge ref_clk);

      observe(14, hi);
      check(hi == '1, "R10 all enabled run", hi, '1);

      host_n = 1'b0;
      settle_wait();
      observe(14, hi);
      check((hi & M_HM) == '0, "R6 host stop", hi & M_HM, '0);
      check((hi & ~M_HM) == ~M_HM, "R8 others run under host stop", hi & ~M_HM, ~M_HM);
      check((hi & M_HM) == '0, "R3 stopped held low", hi & M_HM, '0);

      host_n = 1'b1; bus_n = 1'b0;
      settle_wait();
      observe(14, hi);
      check((hi & M_B) == '0, "R7 bus stop", hi & M_B, '0);
      check((hi & ~M_B) == ~M_B, "R8 others run under bus stop", hi & ~M_B, ~M_B);

      host_n = 1'b0;
      settle_wait();
      observe(14, hi);
      check(hi == M_F, "R8 only free group under both stops", hi, M_F);

      pins_off = 1'b1;
      settle_wait();
      observe(14, hi);
      check(hi == '1, "R9 strap ignores stops", hi, '1);

      pins_off = 1'b0; host_n = 1'b1; bus_n = 1'b1;
      en = {(N/2 + 1){2'b01}};
      settle_wait();
      observe(14, hi);
      check(hi == en, "R10 alternating enables", hi, en);

      en = '1; en[7] = 1'b0;
      settle_wait();
      observe(14, hi);
      check(hi == en, "R11 single output masked", hi, en);

      en = '1;
      settle_wait();
      observe(14, hi);
      check(hi == '1, "R11 restart all", hi, '1);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule